// File: doc/BRIEF.md
# Global shutter exposure sequencer

This block runs one global-shutter exposure with single-slope integration. It works from the system clock, and a separate `tick_i` enable stands in for the granulated sequencer clock. The start and stop requests are separate level inputs, and the sequencer stays suspended for as long as either one is held. It puts out one strobe for each phase:

- a fixed four-tick phase that resets the image core and begins integration;
- an integration phase that lasts until a stop arrives;
- a fixed two-tick phase that makes the image core readable;
- a one-tick ready flag when the exposure is complete.

An integration counter starts on the first tick after the start request is released. It raises a one-tick timeout when its count equals the programmed integration time. A system can feed that timeout back as the stop request, or it can use an independent counter to end the exposure instead.

Top module: `gs_expo_seq`

## Requirements
- R1: After reset, all outputs (`core_rst_o`, `integrate_o`, `readable_o`, `timeout_o`, `ready_o`) are low, and the sequencer stays idle until a start request is seen.
- R2: Both requests are captured on the falling edge of `clk_i`. The sequencer changes state only on a rising edge of `clk_i` while `tick_i` is high. A request that rises and falls between two ticks is never seen.
- R3: While the start request is held, the sequencer is suspended and `core_rst_o` stays low. `core_rst_o` goes high on the first tick that sees the start request low, and it stays high for exactly four tick periods.
- R4: After the reset phase, `integrate_o` is high until a tick sees the stop request high. At most one of `core_rst_o`, `integrate_o`, `readable_o` and `ready_o` is high at any time.
- R5: Ticks are numbered from 1, counting from the first tick that sees the start request released. That tick and each later tick spent in the reset or integration phase advance the count. `timeout_o` goes high at tick `int_time_i`+1 and stays high for exactly one tick period. A value of 0 therefore times out on tick 1. No timeout is raised if integration ends before that tick.
- R6: The counter is one bit wider than `int_time_i` and saturates at all ones without wrapping, so `timeout_o` fires at most once per exposure, however long the exposure lasts.
- R7: While the stop request is held, the sequencer is suspended. `readable_o` goes high on the first tick that sees the stop request low, and it stays high for exactly two tick periods.
- R8: A stop request seen in the idle, start-suspend or reset phase is latched. When the reset phase ends (tick 5), the sequencer then goes straight to stop handling and skips integration.
- R9: After the readable phase, `ready_o` is high for exactly one tick period, and then the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Granulated sequencer clock enable |
| start_req_i | input | 1 | Start request level |
| stop_req_i | input | 1 | Stop request level |
| int_time_i | input | CW | Programmed integration time in ticks |
| core_rst_o | output | 1 | Image core reset / integration start phase |
| integrate_o | output | 1 | Integration in progress |
| readable_o | output | 1 | Image core being made readable |
| timeout_o | output | 1 | Programmed integration count reached |
| ready_o | output | 1 | Exposure complete |

## Verification
The hardest situation to reach from the ports is a stop that arrives before integration has begun. That is the case where the latched stop must hold until the reset phase has run its four ticks. The stimulus gets there in two ways. It raises the stop at the very moment the start request falls, and it also pulses the stop in idle before any start. In both cases the expected first readable tick is clamped to tick 6. Random runs place the stop tick and the tick density so that it falls before, on, and after the timeout tick. A directed exposure runs for more than 512 ticks, and it catches a counter that wraps instead of saturating.

// File: rtl/gs_seq_pkg.sv
package gs_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SUSP_START,
    ST_RESET,
    ST_INTEGRATE,
    ST_SUSP_STOP,
    ST_READABLE,
    ST_DONE
  } seq_state_e;

  localparam int unsigned RESET_TICKS    = 4;
  localparam int unsigned READABLE_TICKS = 2;
endpackage

// File: rtl/gs_req_sample.sv
module gs_req_sample #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] req_o
);
  // capture on the falling edge so the rising-edge sequencer sees settled levels
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_o[g] <= 1'b0;
      else         req_o[g] <= req_i[g];
    end
  end
endmodule

// File: rtl/gs_int_timer.sv
module gs_int_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic          cnt_en_i,
  input  logic [CW-1:0] int_time_i,
  output logic          timeout_o
);
  localparam int unsigned   CNT_W   = CW + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit = cnt_en_i && (cnt_q == {1'b0, int_time_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      timeout_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q     <= '0;
      timeout_o <= 1'b0;
    end else if (tick_i) begin
      timeout_o <= hit;
      if (cnt_en_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  p_timeout_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_o && tick_i) |=> !timeout_o);

  p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !timeout_o));
endmodule

// File: rtl/gs_seq_fsm.sv
module gs_seq_fsm
  import gs_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       start_s_i,
  input  logic       stop_s_i,
  output seq_state_e state_o,
  output logic       cnt_en_o,
  output logic       cnt_clr_o
);
  localparam int unsigned PH_W = 2;
  localparam logic [PH_W-1:0] RST_LAST = PH_W'(RESET_TICKS - 1);
  localparam logic [PH_W-1:0] RD_LAST  = PH_W'(READABLE_TICKS - 1);

  seq_state_e      state_q, state_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            pend_q, pend_d;
  logic            early_ph;

  assign early_ph = (state_q == ST_IDLE) || (state_q == ST_SUSP_START) ||
                    (state_q == ST_RESET);

  always_comb begin
    state_d = state_q;
    ph_d    = ph_q;
    pend_d  = pend_q;
    if (tick_i) begin
      if (stop_s_i && early_ph) pend_d = 1'b1;
      unique case (state_q)
        ST_IDLE:       if (start_s_i) state_d = ST_SUSP_START;
        ST_SUSP_START: if (!start_s_i) begin
          state_d = ST_RESET;
          ph_d    = '0;
        end
        ST_RESET: begin
          if (ph_q == RST_LAST) begin
            // a stop latched earlier is acted on only once reset is done
            if (stop_s_i || pend_q) begin
              state_d = ST_SUSP_STOP;
              pend_d  = 1'b0;
            end else begin
              state_d = ST_INTEGRATE;
            end
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
        ST_INTEGRATE:  if (stop_s_i) state_d = ST_SUSP_STOP;
        ST_SUSP_STOP:  if (!stop_s_i) begin
          state_d = ST_READABLE;
          ph_d    = '0;
        end
        ST_READABLE: begin
          if (ph_q == RD_LAST) state_d = ST_DONE;
          else                 ph_d    = ph_q + 1'b1;
        end
        ST_DONE:       state_d = ST_IDLE;
        default:       state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ph_q    <= ph_d;
      pend_q  <= pend_d;
    end
  end

  assign state_o   = state_q;
  assign cnt_clr_o = (state_q == ST_IDLE);
  assign cnt_en_o  = ((state_q == ST_SUSP_START) && !start_s_i) ||
                     (state_q == ST_RESET) || (state_q == ST_INTEGRATE);

  p_stall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q));

  p_hold_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP_START && start_s_i) |=> (state_q == ST_SUSP_START));

  p_rst_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESET && tick_i && ph_q != RST_LAST) |=> (state_q == ST_RESET));

  p_hold_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SUSP_STOP && stop_s_i) |=> (state_q == ST_SUSP_STOP));

  p_pend_skip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESET && tick_i && ph_q == RST_LAST && pend_q)
      |=> (state_q == ST_SUSP_STOP));

  p_done_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && tick_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/gs_expo_seq.sv
module gs_expo_seq
  import gs_seq_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_req_i,
  input  logic          stop_req_i,
  input  logic [CW-1:0] int_time_i,
  output logic          core_rst_o,
  output logic          integrate_o,
  output logic          readable_o,
  output logic          timeout_o,
  output logic          ready_o
);
  localparam int unsigned NREQ = 2;

  logic [NREQ-1:0] req_s;
  seq_state_e      state;
  logic            cnt_en, cnt_clr;

  gs_req_sample #(.N(NREQ)) u_sample (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  ({stop_req_i, start_req_i}),
    .req_o  (req_s)
  );

  gs_seq_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .start_s_i (req_s[0]),
    .stop_s_i  (req_s[1]),
    .state_o   (state),
    .cnt_en_o  (cnt_en),
    .cnt_clr_o (cnt_clr)
  );

  gs_int_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .clr_i      (cnt_clr),
    .cnt_en_i   (cnt_en),
    .int_time_i (int_time_i),
    .timeout_o  (timeout_o)
  );

  assign core_rst_o  = (state == ST_RESET);
  assign integrate_o = (state == ST_INTEGRATE);
  assign readable_o  = (state == ST_READABLE);
  assign ready_o     = (state == ST_DONE);

  p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({core_rst_o, integrate_o, readable_o, ready_o}));

  p_ready_after_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $past(readable_o));

  p_rd_after_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(readable_o) |-> !$past(req_s[1]));
endmodule

// File: tb/sim_gs_expo_seq.sv
module sim_gs_expo_seq;
  localparam int unsigned CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          start_req = 1'b0;
  logic          stop_req = 1'b0;
  logic [CW-1:0] int_time = '0;
  logic          core_rst, integrate, readable, timeout, ready;

  int total = 0;
  int bad = 0;
  int tick_pct = 100;
  int gt = 0;
  int base = 0;
  bit armed = 0;
  int first_rst, n_rst, n_int, first_rd, n_rd, n_to, to_g, n_rdy, rdy_g;

  always #5 clk = ~clk;

  gs_expo_seq #(.CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .start_req_i(start_req), .stop_req_i(stop_req), .int_time_i(int_time),
    .core_rst_o(core_rst), .integrate_o(integrate), .readable_o(readable),
    .timeout_o(timeout), .ready_o(ready)
  );

  initial begin
    process p;
    p = process::self();
    p.srandom(32'd1234);
    forever begin
      @(posedge clk);
      #1 tick = ($urandom_range(99) < tick_pct);
    end
  end

  // one sample per tick, taken 3 ns after the edge
  always @(posedge clk) begin
    if (tick && rst_n) begin
      gt = gt + 1;
      #3;
      if (armed) begin
        if (core_rst) begin n_rst++; if (first_rst < 0) first_rst = gt; end
        if (integrate) n_int++;
        if (readable) begin n_rd++; if (first_rd < 0) first_rd = gt; end
        if (timeout) begin n_to++; if (to_g < 0) to_g = gt; end
        if (ready) begin n_rdy++; if (rdy_g < 0) rdy_g = gt; end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    @(posedge clk);
    while (!tick) @(posedge clk);
    #2;
  endtask

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // last counted tick: stop handled in integration, or end of reset
  function automatic int exp_last_cnt(int s);
    return imax(s + 1, 5);
  endfunction

  // first readable tick given stop raised after tick s, held h ticks
  function automatic int exp_first_rd(int s, int h);
    return imax(s + h + 1, 6);
  endfunction

  task automatic run(int it, int hs, int s, int h, bit pre);
    int e, r;
    int_time = it[CW-1:0];
    first_rst = -1; first_rd = -1; to_g = -1; rdy_g = -1;
    n_rst = 0; n_int = 0; n_rd = 0; n_to = 0; n_rdy = 0;
    armed = 1;
    if (pre) begin
      stop_req = 1; wait_tick(); wait_tick(); stop_req = 0; wait_tick();
      s = -2; h = 1;
    end
    start_req = 1;
    repeat (hs) wait_tick();
    start_req = 0;
    base = gt;
    if (!pre) begin
      while (gt - base < s) wait_tick();
      stop_req = 1;
      repeat (h) wait_tick();
      stop_req = 0;
    end
    e = exp_last_cnt(s);
    r = exp_first_rd(s, h);
    while (gt - base < r + 4) wait_tick();
    armed = 0;
    chk("R3 first reset tick", first_rst - base, 1);
    chk("R3 reset length", n_rst, 4);
    chk("R4 integrate length", n_int, e - 5);
    chk("R5 timeout count", n_to, (it + 1 <= e) ? 1 : 0);
    if (it + 1 <= e) chk("R5 timeout tick", to_g - base, it + 1);
    chk(pre ? "R8 first readable tick" : "R7 first readable tick", first_rd - base, r);
    chk("R7 readable length", n_rd, 2);
    chk("R9 ready tick", rdy_g - base, r + 2);
    chk("R9 ready length", n_rdy, 1);
  endtask

  initial begin
    #1_500_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    repeat (4) @(posedge clk);
    #6;
    chk("R1 reset outputs", {core_rst, integrate, readable, timeout, ready}, 0);

    // R2: start pulse with no ticks is never seen
    tick_pct = 0;
    repeat (2) @(posedge clk);
    #2 start_req = 1;
    repeat (3) @(posedge clk);
    #2 start_req = 0;
    tick_pct = 100;
    repeat (8) @(posedge clk);
    #6;
    chk("R2 no advance without tick", {core_rst, integrate, readable, ready}, 0);

    // directed corners
    run(0, 2, 10, 2, 0);    // R5 zero int time
    run(3, 1, 0, 1, 0);     // R8 stop at start release
    run(3, 1, 0, 8, 0);     // R8 stop held past reset
    run(4, 3, 0, 0, 1);     // R8 stop pulsed in idle
    run(9, 1, 7, 3, 0);     // R5 stop before timeout
    run(8, 1, 8, 1, 0);     // R5 timeout on stop tick
    run(2, 1, 600, 1, 0);   // R6 long exposure, no wrap
    run(255, 1, 300, 2, 0); // R6 max int time

    for (int i = 0; i < 25; i++) begin
      tick_pct = 30 + $urandom_range(70);
      run($urandom_range(15), 1 + $urandom_range(2),
          $urandom_range(20), 1 + $urandom_range(3), 0);
    end
    tick_pct = 100;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule